// File: doc/BRIEF.md
# ADC Analog Power and Clock Controller

This block is the control logic that moves the analog part of a converter between three conditions: powered down, idle, and working. Software drives it with register-level inputs. These are a power-down request written through a write strobe, level bits for a normal conversion and for offset cancellation, an abort-chain pulse, a trigger-unit enable and a trigger-start flag, and an auto-clock-off enable. A modelled conversion engine sends it trigger pulses, idle offset-refresh requests and a done indication.

The block returns a power-down status bit and an enable for the analog clock. It also issues one-cycle strobes that start a normal conversion, a triggered conversion, an offset cancellation or an offset refresh, and a strobe that aborts the running operation.

Power-down takes effect only at safe points. A request that arrives while an operation is running waits until the converter reports done. A request written while a trigger-started conversion is pending is refused. Work that was cut short by power-down is never restarted by the block on its own.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the power-down request is 1. `pdStatus` reads 1, `anaClkEn` reads 0 and every strobe reads 0 until software clears the request.
- R2: In power-down, a 0-to-1 change of `startBit` or `offCancBit` and a `refreshReq` pulse are ignored. No strobe is issued and `pdStatus` stays 1.
- R3: A `trigPulse` that arrives during power-down is discarded. After power-down is left, no `startTrig` strobe is issued for it.
- R4: A power-down request write with data 1 has no effect while `trigEn` and `trigStart` are both 1. When `trigStart` is 0, the same write is accepted.
- R5: A power-down request accepted while an operation is running does not raise `pdStatus`, and `anaClkEn` stays 1, until `convDone` is seen. `pdStatus` then reads 1 and `anaClkEn` reads 0 from the clock edge that samples `convDone`.
- R6: An `abortChain` pulse during a normal or a triggered conversion ends it. Clearing `startBit` during a normal conversion also ends it, and so does clearing `offCancBit` during an offset cancellation. The abort produces a one-cycle `abortOp` strobe one edge later. `abortChain` has no effect on an offset cancellation.
- R7: After power-down is left, a `startBit` that is still held at 1 starts nothing. A new conversion needs a fresh 0-to-1 change of the bit.
- R8: A request sampled at clock edge k raises `anaClkEn` after edge k. The matching start strobe is 1 for exactly the one cycle after edge k+1.
- R9: With `autoClkOff` = 1, `anaClkEn` is 0 in idle when nothing is pending or running. With `autoClkOff` = 0, `anaClkEn` is 1 in every state except power-down.
- R10: An idle `refreshReq` issues `startRefresh` and keeps `anaClkEn` at 1 until `convDone`. New requests that arrive while an operation runs are ignored.
- R11: Requests sampled on the same edge are taken in this order: trigger first (only when `trigEn` = 1), then normal start, then offset cancellation, then refresh. At most one strobe output is 1 in any cycle.
- R12: A write that clears the power-down request at edge k drops `pdStatus` to 0 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pdWrEn | input | 1 | Write strobe for the power-down request |
| pdWrData | input | 1 | Value written to the power-down request |
| startBit | input | 1 | Normal conversion start bit (level) |
| offCancBit | input | 1 | Offset cancellation bit (level) |
| abortChain | input | 1 | Abort request for normal or triggered conversion (pulse) |
| trigEn | input | 1 | Trigger unit enable |
| trigStart | input | 1 | Trigger-started conversion pending flag |
| autoClkOff | input | 1 | Gate the analog clock when idle |
| trigPulse | input | 1 | Trigger from the trigger unit (pulse) |
| refreshReq | input | 1 | Idle offset refresh request (pulse) |
| convDone | input | 1 | Converter reports the current operation finished |
| pdStatus | output | 1 | Analog part is in power-down |
| anaClkEn | output | 1 | Analog clock enable |
| startNormal | output | 1 | Start strobe, normal conversion |
| startTrig | output | 1 | Start strobe, triggered conversion |
| startOffc | output | 1 | Start strobe, offset cancellation |
| startRefresh | output | 1 | Start strobe, offset refresh |
| abortOp | output | 1 | Abort strobe to the converter |

## Verification
The bench requests power-down in the middle of a conversion and checks that status stays low and the clock stays on until done arrives. A design that powers down at once would cut off the analog clock during a conversion. It pulses a trigger, and sets and holds the start bit, while in power-down, then wakes the block. A design that latched those requests would issue a start strobe that nobody asked for. It writes power-down while a triggered conversion is pending and checks that the write is refused. It also measures the exact edges of clock enable and strobe, and checks that a strobe never reaches the converter while its clock is off. Finally, it raises several requests on the same edge and checks that the ordering picks one winner and discards the others.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    PS_POWERDOWN = 2'd0,
    PS_IDLE      = 2'd1,
    PS_BUSY      = 2'd2,
    PS_DRAIN     = 2'd3
  } pwrState_t;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_NORMAL = 3'd1,
    OP_TRIG   = 3'd2,
    OP_OFFC   = 3'd3,
    OP_REFR   = 3'd4
  } opKind_t;

  // Control-to-datapath command bundle for one cycle
  typedef struct packed {
    logic    loadOp;
    opKind_t newOp;
    logic    clearOp;
    logic    issue;
    logic    abort;
    logic    clkEn;
  } ctlStrobe_t;

endpackage

// File: rtl/adc_pwr_dp.sv
module adc_pwr_dp
  import adc_pwr_pkg::*;
#(
  parameter logic PD_AT_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdWrEn,
  input  logic       pdWrData,
  input  logic       trigEn,
  input  logic       trigStart,
  input  logic       startBit,
  input  logic       offCancBit,
  input  ctlStrobe_t ctl,
  output logic       pdReq,
  output logic       startRise,
  output logic       offRise,
  output opKind_t    opCur,
  output logic       startNormal,
  output logic       startTrig,
  output logic       startOffc,
  output logic       startRefresh,
  output logic       abortOp,
  output logic       anaClkEn
);

  logic    pdReqQ;
  logic    startPrev;
  logic    offPrev;
  opKind_t opQ;
  logic    pdWriteBlocked;
  logic [3:0] strobeQ;

  assign pdWriteBlocked = pdWrData && trigEn && trigStart;
  assign startRise      = startBit && !startPrev;
  assign offRise        = offCancBit && !offPrev;
  assign pdReq          = pdReqQ;
  assign opCur          = opQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdReqQ    <= PD_AT_RESET;
      startPrev <= 1'b0;
      offPrev   <= 1'b0;
      opQ       <= OP_NONE;
      anaClkEn  <= 1'b0;
      abortOp   <= 1'b0;
    end else begin
      if (pdWrEn && !pdWriteBlocked) pdReqQ <= pdWrData;
      startPrev <= startBit;
      offPrev   <= offCancBit;
      if (ctl.clearOp)     opQ <= OP_NONE;
      else if (ctl.loadOp) opQ <= ctl.newOp;
      anaClkEn <= ctl.clkEn;
      abortOp  <= ctl.abort;
    end
  end

  // One strobe register per operation kind
  localparam opKind_t STROBE_KIND [4] = '{OP_NORMAL, OP_TRIG, OP_OFFC, OP_REFR};

  for (genvar gi = 0; gi < 4; gi++) begin : g_strobe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) strobeQ[gi] <= 1'b0;
      else       strobeQ[gi] <= ctl.issue && (opQ == STROBE_KIND[gi]);
    end
  end

  assign startNormal  = strobeQ[0];
  assign startTrig    = strobeQ[1];
  assign startOffc    = strobeQ[2];
  assign startRefresh = strobeQ[3];

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdReq,
  input  logic       startRise,
  input  logic       offRise,
  input  logic       startBit,
  input  logic       offCancBit,
  input  logic       trigEn,
  input  logic       trigPulse,
  input  logic       refreshReq,
  input  logic       abortChain,
  input  logic       convDone,
  input  logic       autoClkOff,
  input  opKind_t    opCur,
  output pwrState_t  state,
  output ctlStrobe_t ctl
);

  pwrState_t stateNext;
  opKind_t   opNext;
  opKind_t   pickOp;
  logic      abortNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_POWERDOWN;
    else       state <= stateNext;
  end

  // Fixed request priority: trigger, normal, offset cancel, refresh
  always_comb begin
    pickOp = OP_NONE;
    if (trigEn && trigPulse) pickOp = OP_TRIG;
    else if (startRise)      pickOp = OP_NORMAL;
    else if (offRise)        pickOp = OP_OFFC;
    else if (refreshReq)     pickOp = OP_REFR;
  end

  always_comb begin
    abortNow = (abortChain && (opCur == OP_NORMAL || opCur == OP_TRIG))
            || (!startBit && opCur == OP_NORMAL)
            || (!offCancBit && opCur == OP_OFFC);
  end

  always_comb begin
    stateNext = state;
    opNext    = opCur;
    ctl       = '0;
    unique case (state)
      PS_POWERDOWN: begin
        if (!pdReq) stateNext = PS_IDLE;
      end
      PS_IDLE: begin
        if (pdReq) begin
          stateNext   = PS_POWERDOWN;
          ctl.clearOp = (opCur != OP_NONE);
          opNext      = OP_NONE;
        end else if (opCur != OP_NONE) begin
          ctl.issue = 1'b1;
          stateNext = PS_BUSY;
        end else if (pickOp != OP_NONE) begin
          ctl.loadOp = 1'b1;
          ctl.newOp  = pickOp;
          opNext     = pickOp;
        end
      end
      PS_BUSY, PS_DRAIN: begin
        if (convDone || abortNow) begin
          ctl.clearOp = 1'b1;
          ctl.abort   = abortNow && !convDone;
          opNext      = OP_NONE;
          stateNext   = pdReq ? PS_POWERDOWN : PS_IDLE;
        end else begin
          stateNext = pdReq ? PS_DRAIN : PS_BUSY;
        end
      end
      default: stateNext = PS_POWERDOWN;
    endcase
    ctl.clkEn = (stateNext != PS_POWERDOWN)
             && (!autoClkOff || stateNext == PS_BUSY || stateNext == PS_DRAIN
                 || opNext != OP_NONE);
  end

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pdWrEn,
  input  logic pdWrData,
  input  logic startBit,
  input  logic offCancBit,
  input  logic abortChain,
  input  logic trigEn,
  input  logic trigStart,
  input  logic autoClkOff,
  input  logic trigPulse,
  input  logic refreshReq,
  input  logic convDone,
  output logic pdStatus,
  output logic anaClkEn,
  output logic startNormal,
  output logic startTrig,
  output logic startOffc,
  output logic startRefresh,
  output logic abortOp
);

  ctlStrobe_t ctl;
  pwrState_t  state;
  opKind_t    opCur;
  logic       pdReq;
  logic       startRise;
  logic       offRise;

  adc_pwr_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .pdReq      (pdReq),
    .startRise  (startRise),
    .offRise    (offRise),
    .startBit   (startBit),
    .offCancBit (offCancBit),
    .trigEn     (trigEn),
    .trigPulse  (trigPulse),
    .refreshReq (refreshReq),
    .abortChain (abortChain),
    .convDone   (convDone),
    .autoClkOff (autoClkOff),
    .opCur      (opCur),
    .state      (state),
    .ctl        (ctl)
  );

  adc_pwr_dp #(.PD_AT_RESET(1'b1)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pdWrEn       (pdWrEn),
    .pdWrData     (pdWrData),
    .trigEn       (trigEn),
    .trigStart    (trigStart),
    .startBit     (startBit),
    .offCancBit   (offCancBit),
    .ctl          (ctl),
    .pdReq        (pdReq),
    .startRise    (startRise),
    .offRise      (offRise),
    .opCur        (opCur),
    .startNormal  (startNormal),
    .startTrig    (startTrig),
    .startOffc    (startOffc),
    .startRefresh (startRefresh),
    .abortOp      (abortOp),
    .anaClkEn     (anaClkEn)
  );

  assign pdStatus = (state == PS_POWERDOWN);

endmodule

// File: rtl/adc_pwr_checker.sv
module adc_pwr_checker (
  input logic clk,
  input logic rstN,
  input logic pdStatus,
  input logic anaClkEn,
  input logic startNormal,
  input logic startTrig,
  input logic startOffc,
  input logic startRefresh,
  input logic abortOp
);

  logic anyStart;
  assign anyStart = startNormal || startTrig || startOffc || startRefresh;

  AST_CLK_AHEAD_OF_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyStart) |-> $past(anaClkEn)); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |=> !anyStart); // R8

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pdStatus |-> (!anaClkEn && !anyStart)); // R2

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startNormal, startTrig, startOffc, startRefresh, abortOp})); // R11

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    abortOp |=> !abortOp); // R6

endmodule

bind adc_pwr_ctrl adc_pwr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pdStatus     (pdStatus),
  .anaClkEn     (anaClkEn),
  .startNormal  (startNormal),
  .startTrig    (startTrig),
  .startOffc    (startOffc),
  .startRefresh (startRefresh),
  .abortOp      (abortOp)
);

// File: tb/adc_pwr_ctrl_test.sv
`timescale 1ns/1ps
module adc_pwr_ctrl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdWrEn = 0, pdWrData = 0, startBit = 0, offCancBit = 0, abortChain = 0;
  logic trigEn = 0, trigStart = 0, autoClkOff = 0, trigPulse = 0, refreshReq = 0, convDone = 0;
  logic pdStatus, anaClkEn, startNormal, startTrig, startOffc, startRefresh, abortOp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cntNormal = 0, cntTrig = 0, cntOffc = 0, cntRefr = 0;

  always #5 clk = ~clk;

  adc_pwr_ctrl uut (
    .clk(clk), .rstN(rstN), .pdWrEn(pdWrEn), .pdWrData(pdWrData),
    .startBit(startBit), .offCancBit(offCancBit), .abortChain(abortChain),
    .trigEn(trigEn), .trigStart(trigStart), .autoClkOff(autoClkOff),
    .trigPulse(trigPulse), .refreshReq(refreshReq), .convDone(convDone),
    .pdStatus(pdStatus), .anaClkEn(anaClkEn), .startNormal(startNormal),
    .startTrig(startTrig), .startOffc(startOffc), .startRefresh(startRefresh),
    .abortOp(abortOp)
  );

  always @(negedge clk) begin
    if (startNormal)  cntNormal++;
    if (startTrig)    cntTrig++;
    if (startOffc)    cntOffc++;
    if (startRefresh) cntRefr++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writePd(input logic v);
    pdWrData = v;
    pdWrEn = 1'b1;
    step(1);
    pdWrEn = 1'b0;
  endtask

  task automatic pulseDone();
    convDone = 1'b1;
    step(1);
    convDone = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1", "pdStatus in reset", pdStatus, 1);
    chk("R1", "anaClkEn in reset", anaClkEn, 0);
    rstN = 1'b1;
    step(2);
    chk("R1", "pdStatus after reset", pdStatus, 1);
    chk("R1", "strobes after reset",
        {startNormal, startTrig, startOffc, startRefresh, abortOp}, 0);
  endtask

  task automatic t_pdIgnore();
    startBit = 1; offCancBit = 1; refreshReq = 1;
    step(1);
    refreshReq = 0;
    step(3);
    chk("R2", "pdStatus held", pdStatus, 1);
    chk("R2", "no start in power-down", cntNormal + cntOffc + cntRefr, 0);
    startBit = 0; offCancBit = 0;
    step(1);
  endtask

  task automatic t_wake();
    writePd(0);
    step(1);
    chk("R12", "pdStatus cleared", pdStatus, 0);
    chk("R9", "clock on, auto-off disabled", anaClkEn, 1);
    step(2);
    chk("R2", "nothing started on wake", cntNormal + cntOffc + cntRefr, 0);
  endtask

  task automatic t_normal();
    autoClkOff = 1;
    step(1);
    chk("R9", "clock off in idle", anaClkEn, 0);
    startBit = 1;
    step(1);
    chk("R8", "clock raised first", anaClkEn, 1);
    chk("R8", "strobe not yet", startNormal, 0);
    step(1);
    chk("R8", "strobe issued", startNormal, 1);
    step(1);
    chk("R8", "strobe one cycle", startNormal, 0);
    chk("R9", "clock on while busy", anaClkEn, 1);
    step(3);
    pulseDone();
    chk("R9", "clock off after done", anaClkEn, 0);
    startBit = 0;
    step(1);
  endtask

  task automatic t_abort();
    startBit = 1;
    step(3);
    abortChain = 1;
    step(1);
    abortChain = 0;
    chk("R6", "abort-chain strobe", abortOp, 1);
    chk("R6", "clock off after abort", anaClkEn, 0);
    step(1);
    chk("R6", "abort one cycle", abortOp, 0);
    startBit = 0;
    step(1);
    offCancBit = 1;
    step(2);
    chk("R8", "offset cancel strobe", startOffc, 1);
    step(2);
    offCancBit = 0;
    step(1);
    chk("R6", "clearing offset bit aborts", abortOp, 1);
    step(1);
    offCancBit = 1;
    step(3);
    abortChain = 1;
    step(1);
    abortChain = 0;
    chk("R6", "abort-chain ignored for offset cancel", abortOp, 0);
    chk("R6", "offset cancel keeps clock", anaClkEn, 1);
    pulseDone();
    chk("R9", "clock off after offset cancel", anaClkEn, 0);
    offCancBit = 0;
    step(1);
  endtask

  task automatic t_drain();
    startBit = 1;
    step(3);
    writePd(1);
    step(1);
    chk("R5", "no status while draining", pdStatus, 0);
    step(3);
    chk("R5", "still draining", pdStatus, 0);
    chk("R5", "clock kept while draining", anaClkEn, 1);
    pulseDone();
    chk("R5", "status after done", pdStatus, 1);
    chk("R5", "clock off after done", anaClkEn, 0);
  endtask

  task automatic t_noResume();
    int snap;
    snap = cntNormal;
    writePd(0);
    step(4);
    chk("R7", "woke up", pdStatus, 0);
    chk("R7", "held start bit not resumed", cntNormal, snap);
    startBit = 0;
    step(1);
    startBit = 1;
    step(2);
    chk("R7", "fresh start accepted", startNormal, 1);
    step(1);
    pulseDone();
    startBit = 0;
    step(1);
  endtask

  task automatic t_trigDrop();
    int snap;
    trigEn = 1;
    writePd(1);
    step(1);
    chk("R3", "entered power-down", pdStatus, 1);
    snap = cntTrig;
    trigPulse = 1;
    step(1);
    trigPulse = 0;
    step(2);
    writePd(0);
    step(4);
    chk("R3", "awake", pdStatus, 0);
    chk("R3", "trigger dropped", cntTrig, snap);
  endtask

  task automatic t_block();
    trigStart = 1;
    writePd(1);
    step(3);
    chk("R4", "write refused", pdStatus, 0);
    trigStart = 0;
    writePd(1);
    step(1);
    chk("R4", "write accepted", pdStatus, 1);
    writePd(0);
    step(1);
    chk("R12", "awake again", pdStatus, 0);
  endtask

  task automatic t_refresh();
    int snap;
    snap = cntNormal;
    refreshReq = 1;
    step(1);
    refreshReq = 0;
    step(1);
    chk("R10", "refresh strobe", startRefresh, 1);
    startBit = 1;
    step(5);
    chk("R10", "clock held during refresh", anaClkEn, 1);
    chk("R10", "start ignored while busy", cntNormal, snap);
    pulseDone();
    chk("R10", "clock off after refresh", anaClkEn, 0);
    startBit = 0;
    step(2);
    chk("R10", "no late start", cntNormal, snap);
  endtask

  task automatic t_priority();
    trigEn = 0;
    trigPulse = 1; startBit = 1;
    step(1);
    trigPulse = 0;
    step(1);
    chk("R11", "disabled trigger loses", startTrig, 0);
    chk("R11", "normal start wins", startNormal, 1);
    step(1);
    pulseDone();
    startBit = 0;
    step(1);
    trigEn = 1;
    trigPulse = 1; startBit = 1; offCancBit = 1;
    step(1);
    trigPulse = 0;
    step(1);
    chk("R11", "trigger wins", startTrig, 1);
    chk("R11", "normal suppressed", startNormal, 0);
    chk("R11", "offset suppressed", startOffc, 0);
    step(1);
    abortChain = 1;
    step(1);
    abortChain = 0;
    chk("R6", "abort-chain ends triggered conversion", abortOp, 1);
    startBit = 0; offCancBit = 0;
    step(2);
  endtask

  initial begin
    t_reset();
    t_pdIgnore();
    t_wake();
    t_normal();
    t_abort();
    t_drain();
    t_noResume();
    t_trigDrop();
    t_block();
    t_refresh();
    t_priority();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule